// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block sits on the host side of a parallel NOR-style flash and programs a consecutive run of words. Software or another block supplies a first address, a last address (inclusive) and a pulse on `start`. The sequencer then takes one data word at a time from a ready/valid stream. For each word it writes a three-cycle unlock prefix and then the program cycle (the word address and the data), and keeps reading the word address until the status shows that the word is finished. It then moves on to the next address.

Completion is judged by data polling. The word is finished when bit 7 of the status read equals bit 7 of the data just written. Bit 5 of the status is the flash's error flag. When it is seen, the sequencer reads once more before it decides, because bit 7 can flip in the same read that raises bit 5. A failure that the second read confirms ends the run: the sequencer writes the reset command F0h to the failing address, raises `error` and holds that address on `failAddr`. A polling budget covers a flash that never answers. When the budget runs out the sequencer takes the same abort path.

Every bus cycle holds its address and data for a set-up time, a strobe time and a recovery time. Each of these is set by a parameter.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error` and `wrReady` are low and both `flWeN` and `flOeN` are high. No bus cycle occurs until `start` is pulsed.
- R2: Each word is preceded by three bus writes, in this order: (address 555h, data 00AAh), (address 2AAh, data 0055h), (address 555h, data 00A0h). Addresses are zero-extended to ADDR_W and data to DATA_W.
- R3: In every write, `flWeN` is low for exactly PULSE_CYC clocks. `flAddr` and `flDout` do not change while a strobe is low or in the cycle in which it rises. `flWeN` and `flOeN` are never low together.
- R4: `wrReady` is high only while the block waits for the next word, and one word is consumed per handshake. After the fourth write of a word (address = word address, data = the word), the block reads the word address (`flOeN` low) until status bit 7 equals data bit 7. The word then counts as programmed.
- R5: Word addresses start at the first address and increase by one up to and including the last address. After the last word completes, `done` rises and stays high until the next `start`.
- R6: A read whose bit 7 does not match and whose bit 5 is 1 is followed by exactly one more read. If that read matches on bit 7, the word counts as programmed and the run continues.
- R7: If that second read still does not match, the block writes data 00F0h to the word address, takes no further words, raises `error` and presents the word address on `failAddr`. Both stay until the next `start`.
- R8: After POLL_LIMIT consecutive reads with neither a bit-7 match nor bit 5 set, the block aborts as in R7: an F0h write, then `error` with `failAddr` set to the word address.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| startAddr | input | ADDR_W | First word address, sampled on start |
| endAddr | input | ADDR_W | Last word address (inclusive), sampled on start |
| wrData | input | DATA_W | Next word to program |
| wrValid | input | 1 | wrData is valid |
| wrReady | output | 1 | Block accepts a word this cycle |
| flAddr | output | ADDR_W | Flash address bus |
| flDout | output | DATA_W | Flash write data |
| flDin | input | DATA_W | Flash read data / status |
| flWeN | output | 1 | Flash write strobe, active low |
| flOeN | output | 1 | Flash output enable, active low |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without error |
| error | output | 1 | Run aborted on failure or timeout |
| failAddr | output | ADDR_W | Failing word address while error is high |

## Verification
The hardest path to reach is the one where bit 5 rises while bit 7 is still wrong, and the very next read nevertheless shows the bit-7 match. That path must end in success, not in an abort. A bench-side flash model reaches it by giving each word its own read index at which bit 5 sets and its own read index at which bit 7 matches. Directed words place the match exactly one read after the error flag. The same two indices, set far apart or never reached, produce the confirmed failure and the timeout. Random jobs then mix all three outcomes into runs of several words, with random first addresses and stalls on the data stream.

// File: rtl/flprog_pkg.sv
package flprog_pkg;
  typedef enum logic [1:0] {ADR_UNLK1, ADR_UNLK2, ADR_WORD} addrSel_e;
  typedef enum logic [2:0] {DAT_AA, DAT_55, DAT_A0, DAT_F0, DAT_WORD} dataSel_e;

  typedef struct packed {
    logic     busGo;
    logic     busRead;
    addrSel_e addrSel;
    dataSel_e dataSel;
    logic     loadRange;
    logic     loadWord;
    logic     incAddr;
    logic     clrPoll;
    logic     incPoll;
  } ctrlStrb_t;

  localparam logic [11:0] UNLK1_ADDR = 12'h555;
  localparam logic [11:0] UNLK2_ADDR = 12'h2AA;
endpackage

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flprog_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int RECOV_CYC  = 1,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] flDin,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flWeN,
  output logic              flOeN,
  output logic              busDone,
  output logic [ADDR_W-1:0] curAddr,
  output logic              atEnd,
  output logic              statusOk,
  output logic              statusErr,
  output logic              pollLast
);
  localparam int MAX_PH = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC) :
                          ((PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC);
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {B_IDLE, B_SET, B_PUL, B_REC} busPh_e;

  busPh_e            busPh;
  logic [PH_W-1:0]   phCnt;
  logic              isRead;
  logic [ADDR_W-1:0] endReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] statusReg;
  logic [POLL_W-1:0] pollCnt;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;

  always_comb begin
    unique case (strb.addrSel)
      ADR_UNLK1: busAddr = ADDR_W'(UNLK1_ADDR);
      ADR_UNLK2: busAddr = ADDR_W'(UNLK2_ADDR);
      default:   busAddr = curAddr;
    endcase
    unique case (strb.dataSel)
      DAT_AA:  busData = DATA_W'(8'hAA);
      DAT_55:  busData = DATA_W'(8'h55);
      DAT_A0:  busData = DATA_W'(8'hA0);
      DAT_F0:  busData = DATA_W'(8'hF0);
      default: busData = dataReg;
    endcase
  end

  // word context: address range, data, poll budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      endReg  <= '0;
      dataReg <= '0;
      pollCnt <= '0;
    end else begin
      if (strb.loadRange) begin
        curAddr <= startAddr;
        endReg  <= endAddr;
      end else if (strb.incAddr) begin
        curAddr <= curAddr + 1'b1;
      end
      if (strb.loadWord) dataReg <= wrData;
      if (strb.clrPoll) pollCnt <= '0;
      else if (strb.incPoll) pollCnt <= pollCnt + 1'b1;
    end
  end

  // one bus cycle: setup, strobe low, recovery, then a done pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPh     <= B_IDLE;
      phCnt     <= '0;
      isRead    <= 1'b0;
      flAddr    <= '0;
      flDout    <= '0;
      flWeN     <= 1'b1;
      flOeN     <= 1'b1;
      busDone   <= 1'b0;
      statusReg <= '0;
    end else begin
      busDone <= 1'b0;
      unique case (busPh)
        B_IDLE: if (strb.busGo) begin
          flAddr <= busAddr;
          flDout <= busData;
          isRead <= strb.busRead;
          phCnt  <= PH_W'(SETUP_CYC - 1);
          busPh  <= B_SET;
        end
        B_SET: if (phCnt == '0) begin
          flWeN <= isRead;
          flOeN <= !isRead;
          phCnt <= PH_W'(PULSE_CYC - 1);
          busPh <= B_PUL;
        end else phCnt <= phCnt - 1'b1;
        B_PUL: if (phCnt == '0) begin
          flWeN <= 1'b1;
          flOeN <= 1'b1;
          if (isRead) statusReg <= flDin;
          phCnt <= PH_W'(RECOV_CYC - 1);
          busPh <= B_REC;
        end else phCnt <= phCnt - 1'b1;
        default: if (phCnt == '0) begin
          busPh   <= B_IDLE;
          busDone <= 1'b1;
        end else phCnt <= phCnt - 1'b1;
      endcase
    end
  end

  assign atEnd     = (curAddr == endReg);
  assign statusOk  = (statusReg[7] == dataReg[7]);
  assign statusErr = statusReg[5];
  assign pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flprog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wrValid,
  input  logic      busDone,
  input  logic      statusOk,
  input  logic      statusErr,
  input  logic      pollLast,
  input  logic      atEnd,
  output ctrlStrb_t strb,
  output logic      wrReady,
  output logic      busy,
  output logic      done,
  output logic      error
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CMD, S_POLL, S_RECHK, S_ABORT, S_DONE, S_FAIL} state_e;

  state_e     state, stateNx;
  logic [1:0] cmdIdx, cmdIdxNx;
  logic       inFlight;
  logic       busState;

  always_comb begin
    strb         = '0;
    strb.addrSel = ADR_WORD;
    strb.dataSel = DAT_WORD;
    stateNx      = state;
    cmdIdxNx     = cmdIdx;
    wrReady      = 1'b0;
    busState     = (state inside {S_CMD, S_POLL, S_RECHK, S_ABORT});
    strb.busGo   = busState && !inFlight;
    case (state)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        strb.loadRange = 1'b1;
        stateNx        = S_FETCH;
      end
      S_FETCH: begin
        wrReady = 1'b1;
        if (wrValid) begin
          strb.loadWord = 1'b1;
          strb.clrPoll  = 1'b1;
          cmdIdxNx      = 2'd0;
          stateNx       = S_CMD;
        end
      end
      S_CMD: begin
        case (cmdIdx)
          2'd0: begin strb.addrSel = ADR_UNLK1; strb.dataSel = DAT_AA; end
          2'd1: begin strb.addrSel = ADR_UNLK2; strb.dataSel = DAT_55; end
          2'd2: begin strb.addrSel = ADR_UNLK1; strb.dataSel = DAT_A0; end
          default: ;
        endcase
        if (busDone) begin
          if (cmdIdx == 2'd3) stateNx = S_POLL;
          else cmdIdxNx = cmdIdx + 2'd1;
        end
      end
      S_POLL: begin
        strb.busRead = 1'b1;
        if (busDone) begin
          if (statusOk) begin
            if (atEnd) stateNx = S_DONE;
            else begin strb.incAddr = 1'b1; stateNx = S_FETCH; end
          end else if (statusErr) stateNx = S_RECHK;
          else if (pollLast) stateNx = S_ABORT;
          else strb.incPoll = 1'b1;
        end
      end
      S_RECHK: begin
        strb.busRead = 1'b1;
        if (busDone) begin
          if (statusOk) begin
            if (atEnd) stateNx = S_DONE;
            else begin strb.incAddr = 1'b1; stateNx = S_FETCH; end
          end else stateNx = S_ABORT;
        end
      end
      S_ABORT: begin
        strb.dataSel = DAT_F0;
        if (busDone) stateNx = S_FAIL;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cmdIdx   <= 2'd0;
      inFlight <= 1'b0;
    end else begin
      state  <= stateNx;
      cmdIdx <= cmdIdxNx;
      if (strb.busGo) inFlight <= 1'b1;
      else if (busDone) inFlight <= 1'b0;
    end
  end

  assign busy  = !(state inside {S_IDLE, S_DONE, S_FAIL});
  assign done  = (state == S_DONE);
  assign error = (state == S_FAIL);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flprog_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int RECOV_CYC  = 1,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  input  logic [DATA_W-1:0] flDin,
  output logic              flWeN,
  output logic              flOeN,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] failAddr
);
  ctrlStrb_t         strb;
  logic              busDone, atEnd, statusOk, statusErr, pollLast;
  logic [ADDR_W-1:0] curAddr;

  flash_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wrValid(wrValid),
    .busDone(busDone), .statusOk(statusOk), .statusErr(statusErr),
    .pollLast(pollLast), .atEnd(atEnd), .strb(strb), .wrReady(wrReady),
    .busy(busy), .done(done), .error(error)
  );

  flash_prog_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .endAddr(endAddr), .wrData(wrData), .flDin(flDin), .flAddr(flAddr),
    .flDout(flDout), .flWeN(flWeN), .flOeN(flOeN), .busDone(busDone),
    .curAddr(curAddr), .atEnd(atEnd), .statusOk(statusOk),
    .statusErr(statusErr), .pollLast(pollLast)
  );

  assign failAddr = error ? curAddr : '0;
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wrReady,
  input logic [ADDR_W-1:0] flAddr,
  input logic [DATA_W-1:0] flDout,
  input logic              flWeN,
  input logic              flOeN,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] failAddr
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN)) else $error("R3: both strobes low");

  p_we_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDout)))
    else $error("R3: address/data moved during write strobe");

  p_we_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> ($stable(flAddr) && $stable(flDout)))
    else $error("R3: address/data moved at strobe rise");

  p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!flOeN && $past(!flOeN)) |-> $stable(flAddr))
    else $error("R3: address moved during read");

  p_ready_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (busy && flWeN && flOeN))
    else $error("R4: ready while bus active");

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done) else $error("R5: done dropped");

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)) else $error("R5: done and error together");

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> (error && $stable(failAddr)))
    else $error("R7: error or failAddr changed");
endmodule

bind flash_prog_seq flash_prog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .wrReady(wrReady), .flAddr(flAddr),
  .flDout(flDout), .flWeN(flWeN), .flOeN(flOeN), .busy(busy), .done(done),
  .error(error), .failAddr(failAddr)
);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int PL = 8;
  localparam int PULSE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0, endAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrValid = 1'b0;
  logic          wrReady, flWeN, flOeN, busy, done, error;
  logic [AW-1:0] flAddr, failAddr;
  logic [DW-1:0] flDout, flDin;

  flash_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(1), .PULSE_CYC(PULSE),
                   .RECOV_CYC(1), .POLL_LIMIT(PL)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .endAddr(endAddr),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .flAddr(flAddr),
    .flDout(flDout), .flDin(flDin), .flWeN(flWeN), .flOeN(flOeN), .busy(busy),
    .done(done), .error(error), .failAddr(failAddr));

  int nRun = 0, nFail = 0;

  // job configuration (written by the main process only)
  logic [DW-1:0] words[8];
  int            dAArr[8];
  int            d5Arr[8];
  logic          clearReq = 1'b0;

  // flash model state (written by the model process only)
  logic [DW-1:0] mem[256];
  logic [AW-1:0] logA[64];
  logic [DW-1:0] logD[64];
  int            rdCnt[8];
  int            wrCnt = 0, curW = -1, readIdx = 0, weLow = 0, r3Bad = 0;
  logic [DW-1:0] pendData = '0;
  logic [AW-1:0] pendAddr = '0, holdA = '0;
  logic          prevWe = 1'b1, prevOe = 1'b1;

  always @(negedge clk) begin
    if (clearReq) begin
      wrCnt = 0; curW = -1; readIdx = 0;
      for (int i = 0; i < 8; i++) rdCnt[i] = 0;
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    end
    if (!flWeN && !flOeN) r3Bad++;
    if (!flWeN) begin
      if (prevWe) holdA = flAddr;
      else if (flAddr !== holdA) r3Bad++;
      weLow++;
    end
    if (flWeN && !prevWe) begin
      if (weLow != PULSE) r3Bad++;
      weLow = 0;
      if (wrCnt < 64) begin logA[wrCnt] = flAddr; logD[wrCnt] = flDout; end
      if (wrCnt % 4 == 3) begin curW++; readIdx = 0; pendData = flDout; pendAddr = flAddr; end
      wrCnt++;
    end
    if (flOeN && !prevOe) begin
      if (curW >= 0 && curW < 8) begin
        rdCnt[curW]++;
        if (readIdx >= dAArr[curW]) mem[pendAddr[7:0]] = pendData;
      end
      readIdx++;
    end
    prevWe = flWeN;
    prevOe = flOeN;
  end

  always_comb begin
    flDin = '0;
    if (curW >= 0 && curW < 8) begin
      if (readIdx >= dAArr[curW]) flDin = pendData;
      else begin
        flDin[7] = ~pendData[7];
        flDin[6] = readIdx[0];
        flDin[5] = (readIdx >= d5Arr[curW]);
      end
    end
  end

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    nRun++;
    if (!good) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected reads for one word from the polling rules (R4, R6, R8)
  function automatic int outcome(input int dA, input int d5, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 1000; n++) begin
      if (n >= dA) begin ok = 1'b1; return n + 1; end
      if (n >= d5) begin ok = (n + 1 >= dA); return n + 2; end
      if (n == PL - 1) return n + 1;
    end
    return 0;
  endfunction

  task automatic runJob(input int sa, input int n, input bit pokeStart);
    int expReads[8];
    int failIdx, nTry, cyc, fed, bad, badU;
    bit ok, fin;
    failIdx = -1;
    for (int j = 0; j < n; j++) begin
      expReads[j] = outcome(dAArr[j], d5Arr[j], ok);
      if (!ok && failIdx < 0) failIdx = j;
    end
    nTry = (failIdx < 0) ? n : failIdx + 1;

    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    start = 1'b1; startAddr = AW'(sa); endAddr = AW'(sa + n - 1);
    @(negedge clk); start = 1'b0;
    fed = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 20000) begin
      @(negedge clk); cyc++;
      start = pokeStart && (cyc == 30);
      if (pokeStart && cyc == 30) begin startAddr = AW'(sa + 77); endAddr = AW'(sa + 90); end
      if (done || error) fin = 1'b1;
      else begin
        if (fed < n) begin wrValid = ($urandom % 4) != 0; wrData = words[fed]; end
        else wrValid = 1'b0;
        if (wrValid && wrReady) fed++;
      end
    end
    wrValid = 1'b0; start = 1'b0;
    chk(fin, "R5", "run finished", cyc, 0);
    repeat (5) @(negedge clk);
    chk(wrReady == 1'b0 && busy == 1'b0, "R4", "idle after run", {wrReady, busy}, 0);
    if (failIdx < 0) begin
      chk(done && !error, "R5", "done held, no error", {done, error}, 2'b10);
      for (int j = 0; j < n; j++)
        chk(mem[8'(sa + j)] == words[j], "R4", "programmed word", mem[8'(sa + j)], words[j]);
    end else begin
      chk(error && !done, "R7 R8", "error held", {done, error}, 2'b01);
      chk(failAddr == AW'(sa + failIdx), "R7 R8", "failAddr", failAddr, sa + failIdx);
      chk(logA[4 * nTry] == AW'(sa + failIdx) && logD[4 * nTry] == 16'h00F0,
          "R7 R8", "reset command after failure", logD[4 * nTry], 16'h00F0);
    end
    chk(wrCnt == 4 * nTry + ((failIdx < 0) ? 0 : 1), "R2 R7", "write count",
        wrCnt, 4 * nTry + ((failIdx < 0) ? 0 : 1));
    bad = 0; badU = 0;
    for (int j = 0; j < nTry; j++) begin
      if (logA[4*j] != 21'h555 || logD[4*j] != 16'h00AA ||
          logA[4*j+1] != 21'h2AA || logD[4*j+1] != 16'h0055 ||
          logA[4*j+2] != 21'h555 || logD[4*j+2] != 16'h00A0) badU++;
      if (logA[4*j+3] != AW'(sa + j) || logD[4*j+3] != words[j]) bad++;
    end
    chk(badU == 0, "R2", "unlock prefix mismatches", badU, 0);
    chk(bad == 0, pokeStart ? "R5 R9" : "R5", "program address/data mismatches", bad, 0);
    bad = 0;
    for (int j = 0; j < nTry; j++) if (rdCnt[j] != expReads[j]) bad++;
    chk(bad == 0, "R4 R6 R8", "words with wrong poll count", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin dAArr[i] = 99; d5Arr[i] = 99; words[i] = '0; end
    clearReq = 1'b1;
    repeat (3) @(negedge clk);
    clearReq = 1'b0;
    chk(!busy && !done && !error && !wrReady && flWeN && flOeN, "R1", "state in reset",
        {busy, done, error, wrReady, flWeN, flOeN}, 6'b000011);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !done && !error && !wrReady && flWeN && flOeN && wrCnt == 0, "R1",
        "idle without start", wrCnt, 0);

    // single word, first address equals last
    words[0] = 16'h1234; dAArr[0] = 2; d5Arr[0] = 99;
    runJob(10, 1, 1'b0);
    // several words, bit 7 of data both 0 and 1
    words[0] = 16'h00FF; words[1] = 16'hFF00; words[2] = 16'h8001; words[3] = 16'h7FFE;
    dAArr[0] = 0; dAArr[1] = 3; dAArr[2] = 1; dAArr[3] = 5;
    for (int i = 0; i < 4; i++) d5Arr[i] = 99;
    runJob(20, 4, 1'b0);
    // R6: error flag rises, bit 7 matches on the re-read
    words[0] = 16'hA5A5; dAArr[0] = 3; d5Arr[0] = 2;
    words[1] = 16'h5A5A; dAArr[1] = 1; d5Arr[1] = 0;
    runJob(40, 2, 1'b0);
    // R7: confirmed failure on second word
    words[0] = 16'h0101; dAArr[0] = 1; d5Arr[0] = 99;
    words[1] = 16'h8282; dAArr[1] = 99; d5Arr[1] = 1;
    words[2] = 16'h0303; dAArr[2] = 0; d5Arr[2] = 99;
    runJob(60, 3, 1'b0);
    // R8: flash never completes
    words[0] = 16'hC0DE; dAArr[0] = 99; d5Arr[0] = 99;
    words[1] = 16'h0BAD; dAArr[1] = 0; d5Arr[1] = 99;
    runJob(80, 2, 1'b0);
    // R9: start pulse in the middle of a run
    for (int i = 0; i < 5; i++) begin words[i] = 16'(16'h1111 * (i + 1)); dAArr[i] = i; d5Arr[i] = 99; end
    runJob(100, 5, 1'b1);

    for (int k = 0; k < 20; k++) begin
      int n, r;
      n = 1 + $urandom % 6;
      for (int i = 0; i < n; i++) begin
        words[i] = 16'($urandom);
        dAArr[i] = $urandom % 5;
        r = $urandom % 10;
        if (r < 7) d5Arr[i] = 99;
        else if (r < 9) d5Arr[i] = $urandom % 4;
        else begin dAArr[i] = 99; d5Arr[i] = 99; end
      end
      runJob($urandom % 200, n, 1'b0);
    end

    chk(r3Bad == 0, "R3", "strobe timing violations", r3Bad, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (R1..all) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun + 1, nFail + 1);
    $finish;
  end
endmodule